// File: doc/BRIEF.md
# Byte-Lane Access Unit with Alignment Trap

This block sits between a core's load/store path and a 16-bit data memory. The memory is held inside the block as two byte-wide lanes. Both lanes are addressed by the same word index, and each lane has its own write strobe. Each request carries one access, either a read or a write, with a byte or word operand size. A request also carries a pointer value and a pointer-update mode. The block forms the effective byte address from the pointer and the mode. It performs the access and returns the updated pointer, with the step scaled to the operand size.

On a byte read the block fetches the whole word and moves the addressed byte to the low eight bits of the read data. A byte write enables only the lane that holds the addressed byte. A word access to an odd byte address is misaligned. If it is a read, the read still returns data. If it is a write, no lane is written. In both cases a one-cycle trap request is raised, and the faulting address is captured for the core's exception logic. The block does not vector the trap.

All results appear in the cycle after the request is accepted.

Top module: `byte_lane_unit`

## Requirements
- R1: A request accepted on a clock edge (`req_valid` high) gives `rsp_valid` high for exactly the following cycle. An aligned word read then returns the stored word on `rd_data`: the even byte on bits 7:0 and the odd byte on bits 15:8.
- R2: A byte read returns the byte at the effective address on `rd_data[7:0]`, with `rd_data[15:8]` zero. Address bit 0 picks the byte: 0 selects the low lane (bits 7:0 of the word) and 1 selects the high lane (bits 15:8). `rd_data` is zero in every cycle that is not a read response.
- R3: A byte write stores `req_wdata[7:0]` into the addressed lane only. The other byte of that word keeps its value.
- R4: An aligned word write stores `req_wdata[7:0]` at the even byte and `req_wdata[15:8]` at the odd byte.
- R5: A word access whose effective address is odd pulses `trap_req` high for exactly one cycle, in the cycle after the request, and loads `trap_addr` with that effective address. Byte accesses and aligned word accesses never raise `trap_req`.
- R6: A misaligned word read still completes. It returns the word whose byte pair contains the effective address, with bit 0 ignored.
- R7: A misaligned word write writes neither lane, so memory is unchanged. `wr_blocked` pulses high in the cycle after the request.
- R8: `req_mode` selects the effective address. In modes 0 (no update), 1 (post-increment) and 2 (post-decrement) the address is `req_ptr`. In mode 3 (pre-decrement) the address is `req_ptr` minus the step.
- R9: `ptr_out` gives the updated pointer. Mode 0 leaves it at `req_ptr`, mode 1 adds the step, and modes 2 and 3 subtract the step. The step is 1 for byte operands and 2 for word operands. The arithmetic wraps modulo 2^AW, and the update still takes effect on a trapped access.
- R10: After reset, `rsp_valid`, `rd_data`, `ptr_out`, `trap_req`, `trap_addr` and `wr_blocked` are all zero.
- R11: `trap_addr` holds its value until the next trapping access.
- R12: The word index is taken from effective-address bits log2(DEPTH_WORDS):1. Higher address bits are ignored, so the memory aliases across the pointer space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte operand, 0 = word operand |
| req_mode | input | 2 | Pointer mode: 0 none, 1 post-inc, 2 post-dec, 3 pre-dec |
| req_ptr | input | AW | Pointer (byte address) before update |
| req_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rsp_valid | output | 1 | Response cycle for the previous request |
| rd_data | output | 16 | Read data, byte reads zero-extended |
| ptr_out | output | AW | Updated pointer |
| trap_req | output | 1 | One-cycle address-error trap request |
| trap_addr | output | AW | Effective address of the last trapping access |
| wr_blocked | output | 1 | One-cycle pulse when a misaligned write was dropped |

## Verification
The bound checker watches the per-cycle relations between request and response on every cycle:
- the response and trap pulses that follow a request;
- that exactly one lane strobe fires on a byte write, both on an aligned word write, and none on a misaligned word write;
- the zero upper byte of byte reads;
- the scaled pointer step.

Other properties depend on what memory holds, so only the bench's sweeps can show them:
- that the untouched byte of a word survives a byte write;
- that a dropped write really leaves memory unchanged;
- that a misaligned read returns the right word;
- aliasing and wrap of the pointer.

These sweeps compare every response against a byte-level model of the memory.

// File: rtl/blu_pkg.sv
package blu_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef enum logic [1:0] {
    PM_NONE     = 2'd0,
    PM_POST_INC = 2'd1,
    PM_POST_DEC = 2'd2,
    PM_PRE_DEC  = 2'd3
  } ptr_mode_e;
endpackage

// File: rtl/blu_addr_gen.sv
module blu_addr_gen #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ptr_in,
  input  logic [1:0]    mode,
  input  logic          byte_op,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] ptr_next,
  output logic          misal
);
  import blu_pkg::*;

  logic [AW-1:0] step;
  logic [AW-1:0] ptr_inc;
  logic [AW-1:0] ptr_dec;

  always_comb begin
    step    = byte_op ? AW'(1) : AW'(2);
    ptr_inc = ptr_in + step;
    ptr_dec = ptr_in - step;
    unique case (ptr_mode_e'(mode))
      PM_NONE:     begin ea = ptr_in;  ptr_next = ptr_in;  end
      PM_POST_INC: begin ea = ptr_in;  ptr_next = ptr_inc; end
      PM_POST_DEC: begin ea = ptr_in;  ptr_next = ptr_dec; end
      default:     begin ea = ptr_dec; ptr_next = ptr_dec; end
    endcase
    misal = !byte_op && ea[0];
  end
endmodule

// File: rtl/blu_lane_ram.sv
module blu_lane_ram #(
  parameter int DEPTH_WORDS = 64,
  localparam int IW = $clog2(DEPTH_WORDS)
) (
  input  logic                        clk,
  input  logic [blu_pkg::LANES-1:0]   we,
  input  logic [IW-1:0]               idx,
  input  logic [blu_pkg::WORD_W-1:0]  wdata,
  output logic [blu_pkg::WORD_W-1:0]  rdata
);
  import blu_pkg::*;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH_WORDS];
    always_ff @(posedge clk) begin
      if (we[g]) mem[idx] <= wdata[g*LANE_W +: LANE_W];
      rdata[g*LANE_W +: LANE_W] <= mem[idx];
    end
  end
endmodule

// File: rtl/blu_steer.sv
module blu_steer (
  input  logic [blu_pkg::WORD_W-1:0] raw,
  input  logic                       enable,
  input  logic                       byte_op,
  input  logic                       odd,
  output logic [blu_pkg::WORD_W-1:0] data
);
  import blu_pkg::*;

  logic [LANE_W-1:0] pick;

  always_comb begin
    pick = odd ? raw[WORD_W-1 -: LANE_W] : raw[LANE_W-1:0];
    if (!enable)      data = '0;
    else if (byte_op) data = {{(WORD_W-LANE_W){1'b0}}, pick};
    else              data = raw;
  end
endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit #(
  parameter int AW          = 16,
  parameter int DEPTH_WORDS = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_byte,
  input  logic [1:0]    req_mode,
  input  logic [AW-1:0] req_ptr,
  input  logic [15:0]   req_wdata,
  output logic          rsp_valid,
  output logic [15:0]   rd_data,
  output logic [AW-1:0] ptr_out,
  output logic          trap_req,
  output logic [AW-1:0] trap_addr,
  output logic          wr_blocked
);
  import blu_pkg::*;

  localparam int IW = $clog2(DEPTH_WORDS);

  logic [AW-1:0]     ea;
  logic [AW-1:0]     ptr_next;
  logic              misal;
  logic [LANES-1:0]  lane_we;
  logic [WORD_W-1:0] ram_wdata;
  logic [WORD_W-1:0] ram_rdata;
  logic [IW-1:0]     word_idx;

  logic rsp_rd_q;
  logic rsp_byte_q;
  logic rsp_odd_q;

  blu_addr_gen #(.AW(AW)) u_addr (
    .ptr_in   (req_ptr),
    .mode     (req_mode),
    .byte_op  (req_byte),
    .ea       (ea),
    .ptr_next (ptr_next),
    .misal    (misal)
  );

  assign word_idx = ea[IW:1];

  always_comb begin
    lane_we = '0;
    if (req_valid && req_write) begin
      if (req_byte)   lane_we[ea[0]] = 1'b1;
      else if (!misal) lane_we = '1;
    end
    ram_wdata[LANE_W-1:0]      = req_wdata[LANE_W-1:0];
    ram_wdata[WORD_W-1 -: LANE_W] = req_byte ? req_wdata[LANE_W-1:0]
                                             : req_wdata[WORD_W-1 -: LANE_W];
  end

  blu_lane_ram #(.DEPTH_WORDS(DEPTH_WORDS)) u_ram (
    .clk   (clk),
    .we    (lane_we),
    .idx   (word_idx),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_rd_q   <= 1'b0;
      rsp_byte_q <= 1'b0;
      rsp_odd_q  <= 1'b0;
      ptr_out    <= '0;
      trap_req   <= 1'b0;
      trap_addr  <= '0;
      wr_blocked <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_rd_q   <= req_valid && !req_write;
      rsp_byte_q <= req_byte;
      rsp_odd_q  <= ea[0];
      trap_req   <= req_valid && misal;
      wr_blocked <= req_valid && misal && req_write;
      if (req_valid) ptr_out <= ptr_next;
      if (req_valid && misal) trap_addr <= ea;
    end
  end

  blu_steer u_steer (
    .raw     (ram_rdata),
    .enable  (rsp_rd_q),
    .byte_op (rsp_byte_q),
    .odd     (rsp_odd_q),
    .data    (rd_data)
  );
endmodule

// File: rtl/blu_checker.sv
module blu_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic          req_byte,
  input logic [1:0]    req_mode,
  input logic [AW-1:0] req_ptr,
  input logic [1:0]    lane_we,
  input logic          rsp_valid,
  input logic [15:0]   rd_data,
  input logic [AW-1:0] ptr_out,
  input logic          trap_req,
  input logic          wr_blocked
);
  logic word_odd;
  assign word_odd = req_valid && !req_byte && req_ptr[0];

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_byte_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_byte) |=> (rd_data[15:8] == 8'h00));
  p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_byte) |-> ($countones(lane_we) == 1));
  p_idle_no_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |-> (lane_we == 2'b00));
  p_word_both_lanes_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !req_byte && !req_ptr[0]) |-> (lane_we == 2'b11));
  p_trap_on_odd_word_r5: assert property (@(posedge clk) disable iff (rst)
    word_odd |=> trap_req);
  p_no_trap_otherwise_r5: assert property (@(posedge clk) disable iff (rst)
    !word_odd |=> !trap_req);
  p_trap_with_rsp_r6: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> rsp_valid);
  p_block_strobes_r7: assert property (@(posedge clk) disable iff (rst)
    (word_odd && req_write) |-> (lane_we == 2'b00));
  p_block_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (word_odd && req_write) |=> wr_blocked);
  p_byte_post_inc_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_byte && req_mode == 2'd1) |=> (ptr_out == $past(req_ptr) + AW'(1)));
  p_word_pre_dec_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_byte && req_mode == 2'd3) |=> (ptr_out == $past(req_ptr) - AW'(2)));
  p_mode_none_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd0) |=> (ptr_out == $past(req_ptr)));
endmodule

bind byte_lane_unit blu_checker #(.AW(AW)) u_blu_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_byte   (req_byte),
  .req_mode   (req_mode),
  .req_ptr    (req_ptr),
  .lane_we    (lane_we),
  .rsp_valid  (rsp_valid),
  .rd_data    (rd_data),
  .ptr_out    (ptr_out),
  .trap_req   (trap_req),
  .wr_blocked (wr_blocked)
);

// File: tb/byte_lane_unit_bench.sv
module byte_lane_unit_bench;
  localparam int AW    = 16;
  localparam int DEPTH = 64;
  localparam int NB    = 2 * DEPTH;
  localparam int BW    = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_byte = 1'b0;
  logic [1:0]    req_mode = 2'd0;
  logic [AW-1:0] req_ptr = '0;
  logic [15:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [15:0]   rd_data;
  logic [AW-1:0] ptr_out;
  logic          trap_req;
  logic [AW-1:0] trap_addr;
  logic          wr_blocked;

  int total = 0;
  int bad = 0;
  logic [7:0] model [NB];
  logic [AW-1:0] last_trap = '0;

  always #10 clk = ~clk;

  byte_lane_unit #(.AW(AW), .DEPTH_WORDS(DEPTH)) u_byte_lane_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_byte(req_byte), .req_mode(req_mode), .req_ptr(req_ptr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rd_data(rd_data),
    .ptr_out(ptr_out), .trap_req(trap_req), .trap_addr(trap_addr),
    .wr_blocked(wr_blocked)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] ea_of(input logic [1:0] m, input logic [AW-1:0] p,
                                          input logic b);
    logic [AW-1:0] s = b ? AW'(1) : AW'(2);
    return (m == 2'd3) ? p - s : p;
  endfunction

  function automatic logic [AW-1:0] nxt_of(input logic [1:0] m, input logic [AW-1:0] p,
                                           input logic b);
    logic [AW-1:0] s = b ? AW'(1) : AW'(2);
    if (m == 2'd0) return p;
    if (m == 2'd1) return p + s;
    return p - s;
  endfunction

  // One access; drives at a falling edge, checks at the next falling edge.
  task automatic access(input logic w, input logic b, input logic [1:0] m,
                        input logic [AW-1:0] p, input logic [15:0] wd);
    logic [AW-1:0] ea;
    logic [BW-1:0] bi;
    logic [BW-1:0] ev;
    logic mis;
    logic [15:0] exp;
    ea  = ea_of(m, p, b);
    bi  = ea[BW-1:0];
    ev  = {bi[BW-1:1], 1'b0};
    mis = !b && ea[0];
    req_valid = 1'b1; req_write = w; req_byte = b; req_mode = m;
    req_ptr = p; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid === 1'b1, "R1 rsp_valid", 32'(rsp_valid), 32'd1);
    chk(ptr_out === nxt_of(m, p, b), "R9/R8 ptr_out", 32'(ptr_out), 32'(nxt_of(m, p, b)));
    chk(trap_req === mis, "R5 trap_req", 32'(trap_req), 32'(mis));
    if (mis) last_trap = ea;
    chk(trap_addr === last_trap, "R11/R5 trap_addr", 32'(trap_addr), 32'(last_trap));
    chk(wr_blocked === (mis && w), "R7 wr_blocked", 32'(wr_blocked), 32'(mis && w));
    if (!w) begin
      if (b) exp = {8'h00, model[bi]};
      else   exp = {model[ev + 1'b1], model[ev]};
      chk(rd_data === exp, b ? "R2 byte read" : (mis ? "R6 misaligned read" : "R1 word read"),
          32'(rd_data), 32'(exp));
    end else begin
      chk(rd_data === 16'h0, "R2 rd_data idle on write", 32'(rd_data), 32'h0);
      if (b) model[bi] = wd[7:0];
      else if (!mis) begin
        model[ev] = wd[7:0];
        model[ev + 1'b1] = wd[15:8];
      end
    end
  endtask

  task automatic idle_check();
    @(negedge clk);
    chk(trap_req === 1'b0, "R5 trap pulse one cycle", 32'(trap_req), 32'h0);
    chk(wr_blocked === 1'b0, "R7 blocked pulse one cycle", 32'(wr_blocked), 32'h0);
    chk(rsp_valid === 1'b0, "R1 rsp one cycle", 32'(rsp_valid), 32'h0);
    chk(rd_data === 16'h0, "R2 rd_data zero when idle", 32'(rd_data), 32'h0);
    chk(trap_addr === last_trap, "R11 trap_addr held", 32'(trap_addr), 32'(last_trap));
  endtask

  task automatic read_all_words();
    for (int i = 0; i < NB; i += 2) access(1'b0, 1'b0, 2'd0, AW'(i), 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10 reset state
    chk(rsp_valid === 1'b0, "R10 rsp_valid", 32'(rsp_valid), 0);
    chk(rd_data === 16'h0, "R10 rd_data", 32'(rd_data), 0);
    chk(ptr_out === '0, "R10 ptr_out", 32'(ptr_out), 0);
    chk(trap_req === 1'b0, "R10 trap_req", 32'(trap_req), 0);
    chk(trap_addr === '0, "R10 trap_addr", 32'(trap_addr), 0);
    chk(wr_blocked === 1'b0, "R10 wr_blocked", 32'(wr_blocked), 0);

    // R4: fill with aligned word writes, post-increment
    for (int i = 0; i < NB; i += 2)
      access(1'b1, 1'b0, 2'd1, AW'(i), 16'(i * 16'h0301) ^ 16'hA55A);
    read_all_words();

    // R3: byte writes on every third byte address, upper wdata junk
    for (int i = 0; i < NB; i += 3)
      access(1'b1, 1'b1, 2'd1, AW'(i), {8'hEE, 8'(i * 7 + 1)});
    read_all_words();

    // R2: byte reads at every address, post-decrement
    for (int i = 0; i < NB; i++) access(1'b0, 1'b1, 2'd2, AW'(i), 16'h0);

    // R5/R6: misaligned word reads, then pulse and hold check
    for (int i = 1; i < NB; i += 2) begin
      access(1'b0, 1'b0, 2'd0, AW'(i), 16'h0);
      idle_check();
    end

    // R7: misaligned word writes via pre-decrement, memory must stay unchanged
    for (int i = 3; i < NB; i += 4) begin
      access(1'b1, 1'b0, 2'd3, AW'(i), 16'hDEAD);
      idle_check();
    end
    read_all_words();

    // R8: pre-decrement byte read and word write
    access(1'b0, 1'b1, 2'd3, AW'(9), 16'h0);
    access(1'b1, 1'b0, 2'd3, AW'(20), 16'h1234);
    access(1'b0, 1'b0, 2'd0, AW'(18), 16'h0);

    // R9/R12: wrap and aliasing
    access(1'b0, 1'b0, 2'd2, AW'(0), 16'h0);
    access(1'b1, 1'b1, 2'd1, 16'hFFFF, 16'h0077);
    access(1'b0, 1'b0, 2'd0, 16'h007E, 16'h0);
    access(1'b0, 1'b0, 2'd0, 16'h4002, 16'h0);
    access(1'b1, 1'b0, 2'd3, 16'h0001, 16'hBEEF);
    idle_check();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule